// File: doc/BRIEF.md
# Program Counter and Return Stack Unit

This block keeps the 13-bit fetch address of a small accumulator processor and decides where the next fetch goes. Each clock edge is one instruction cycle. The decoder presents one operation code per cycle. The code selects one of these actions:

- step on by one;
- jump or call to an 11-bit literal, with the top two address bits taken from a software-loaded holding latch;
- return through an eight-entry hardware stack, in one of three flavours;
- computed jump, made by writing a new low byte.

A computed jump loads the whole upper part of the address from the 5-bit holding latch. Nothing carries in from the low byte.

Every load that is not a plain step raises a one-cycle flush. The decoder uses it to turn the word already fetched into a no-operation. The unit ignores any code or latch write presented during that cycle. A return from interrupt also gives a one-cycle pulse that sets the global interrupt enable bit elsewhere in the core.

All pins are plain control and status. There is no data stream and no back-pressure, and an operation is taken on every edge.

Top module: `pc_seq_unit`

## Requirements
- R1: After reset the fetch address, the holding latch, the flush output and the interrupt-enable pulse are all zero.
- R2: Operation code 0 (step) and the reserved code 7 advance the address by one with no flush, and 0x1FFF advances to 0x0000.
- R3: Code 1 (jump) loads the literal into address bits 10..0 and latch bits 4..3 into address bits 12..11.
- R4: Code 2 (call) pushes the current fetch address, which is the word after the call, then loads the target as in R3.
- R5: Code 3 (return) and code 4 (return with literal) pop the most recently pushed address into the fetch address.
- R6: Code 5 (return from interrupt) pops as in R5 and gives an interrupt-enable pulse exactly in the following cycle.
- R7: Code 6 (low-byte write) loads the 8-bit data into address bits 7..0 and all five latch bits into bits 12..8, with no carry from the old low byte.
- R8: The readable low byte always equals address bits 7..0. The latch changes only through its write strobe, and reading leaves it unchanged.
- R9: The flush output is high for exactly the one cycle after each load in R3 to R7. In that cycle the address steps by one, and the operation code and the latch write are ignored.
- R10: The stack is eight entries deep and circular. A ninth push overwrites the oldest entry, and a pop past the bottom wraps around, with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code for this cycle (0 step, 1 jump, 2 call, 3 return, 4 return with literal, 5 return from interrupt, 6 low-byte write, 7 reserved) |
| lit_i | input | 11 | Jump or call literal |
| low_wdata_i | input | 8 | ALU result written as the new low byte |
| lat_we_i | input | 1 | Holding latch write strobe |
| lat_wdata_i | input | 5 | Holding latch write data |
| pc_o | output | 13 | Current fetch address |
| pcl_o | output | 8 | Readable low byte of the address |
| lat_o | output | 5 | Holding latch contents |
| gie_set_o | output | 1 | One-cycle request to set global interrupt enable |
| flush_o | output | 1 | Discard the word fetched in this cycle |

## Verification
Jumps are tried with latch values whose top bits differ from the current address, so a design that keeps the old upper bits is caught. The wrap from 0x1FFF and a low-byte write after a low byte of 0xF8 show whether any carry leaks into the upper part. Nested calls finished by different return kinds tell the pop order apart, and only one of them must raise the interrupt pulse. Nine calls followed by nine returns show the overwrite of the oldest entry and the wrap of the pointer. Codes and latch writes issued during a flush cycle must leave no trace.

// File: rtl/pc_seq_pkg.sv
`timescale 1ns/1ps
package pc_seq_pkg;
  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_RETL  = 3'd4,
    OP_RETI  = 3'd5,
    OP_LOWWR = 3'd6,
    OP_RSVD  = 3'd7
  } pc_op_e;

  typedef struct packed {
    logic redirect;
    logic push;
    logic pop;
    logic gie;
  } pc_ctl_t;
endpackage

// File: rtl/pc_hold_latch.sv
`timescale 1ns/1ps
module pc_hold_latch #(
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LAT_W-1:0] wdata,
  output logic [LAT_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (we) q <= wdata;
  end

  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> q == $past(q)); // R8
endmodule

// File: rtl/pc_ret_stack.sv
`timescale 1ns/1ps
module pc_ret_stack #(
  parameter int AW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [AW-1:0]    ent [DEPTH];
  logic [PTR_W-1:0] sp;
  logic [PTR_W-1:0] sp_inc, sp_dec;

  // Circular pointer arithmetic that also holds for depths that are not powers of two
  always_comb begin
    sp_inc = (sp == LAST) ? '0 : sp + 1'b1;
    sp_dec = (sp == '0) ? LAST : sp - 1'b1;
  end

  assign top_o = ent[sp_dec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (push) begin
      ent[sp] <= push_data;
      sp      <= sp_inc;
    end else if (pop) begin
      sp <= sp_dec;
    end
  end

  AST_PUSH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_o == $past(push_data)); // R10
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R4
endmodule

// File: rtl/pc_next_sel.sv
`timescale 1ns/1ps
module pc_next_sel
  import pc_seq_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LIT_W = 11,
  parameter int LOW_W = 8
) (
  input  pc_op_e                op,
  input  logic [PC_W-1:0]       pc,
  input  logic [PC_W-LOW_W-1:0] lat,
  input  logic [LIT_W-1:0]      lit,
  input  logic [LOW_W-1:0]      low_data,
  input  logic [PC_W-1:0]       stack_top,
  output logic [PC_W-1:0]       nxt_pc,
  output pc_ctl_t               ctl
);
  localparam int LAT_W = PC_W - LOW_W;
  localparam int JHI   = PC_W - LIT_W;

  logic [PC_W-1:0] far_tgt, comp_tgt;

  // Jump/call target: page bits come from the top of the latch
  assign far_tgt  = {lat[LAT_W-1 -: JHI], lit};
  // Computed jump: the whole upper part comes from the latch
  assign comp_tgt = {lat, low_data};

  always_comb begin
    nxt_pc = pc + 1'b1;
    ctl    = '0;
    unique case (op)
      OP_JUMP: begin
        nxt_pc       = far_tgt;
        ctl.redirect = 1'b1;
      end
      OP_CALL: begin
        nxt_pc       = far_tgt;
        ctl.redirect = 1'b1;
        ctl.push     = 1'b1;
      end
      OP_RET, OP_RETL: begin
        nxt_pc       = stack_top;
        ctl.redirect = 1'b1;
        ctl.pop      = 1'b1;
      end
      OP_RETI: begin
        nxt_pc       = stack_top;
        ctl.redirect = 1'b1;
        ctl.pop      = 1'b1;
        ctl.gie      = 1'b1;
      end
      OP_LOWWR: begin
        nxt_pc       = comp_tgt;
        ctl.redirect = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pc_seq_unit.sv
`timescale 1ns/1ps
module pc_seq_unit
  import pc_seq_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LIT_W   = 11,
  parameter int LOW_W   = 8,
  parameter int STACK_D = 8,
  parameter int LAT_W   = PC_W - LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [LIT_W-1:0] lit_i,
  input  logic [LOW_W-1:0] low_wdata_i,
  input  logic             lat_we_i,
  input  logic [LAT_W-1:0] lat_wdata_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [LOW_W-1:0] pcl_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             gie_set_o,
  output logic             flush_o
);
  logic [PC_W-1:0] pc_q, nxt_pc, stack_top;
  logic            flush_q, gie_q;
  pc_op_e          op_eff;
  pc_ctl_t         ctl;

  // The word fetched in a flush cycle is discarded, so its code is not acted on
  assign op_eff = flush_q ? OP_STEP : pc_op_e'(op_i);

  pc_hold_latch #(.LAT_W(LAT_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lat_we_i & ~flush_q),
    .wdata (lat_wdata_i),
    .q     (lat_o)
  );

  pc_next_sel #(.PC_W(PC_W), .LIT_W(LIT_W), .LOW_W(LOW_W)) u_sel (
    .op        (op_eff),
    .pc        (pc_q),
    .lat       (lat_o),
    .lit       (lit_i),
    .low_data  (low_wdata_i),
    .stack_top (stack_top),
    .nxt_pc    (nxt_pc),
    .ctl       (ctl)
  );

  pc_ret_stack #(.AW(PC_W), .DEPTH(STACK_D)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ctl.push),
    .pop       (ctl.pop),
    .push_data (pc_q),
    .top_o     (stack_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
      gie_q   <= 1'b0;
    end else begin
      pc_q    <= nxt_pc;
      flush_q <= ctl.redirect;
      gie_q   <= ctl.gie;
    end
  end

  assign pc_o      = pc_q;
  assign pcl_o     = pc_q[LOW_W-1:0];
  assign flush_o   = flush_q;
  assign gie_set_o = gie_q;

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && (op_i == 3'd0 || op_i == 3'd7)) |=> pc_o == $past(pc_o) + 1'b1); // R2
  AST_JUMP_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && op_i == 3'd1) |=> pc_o[LIT_W-1:0] == $past(lit_i)); // R3
  AST_LOWWR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && op_i == 3'd6) |=> pc_o[PC_W-1:LOW_W] == $past(lat_o)); // R7
  AST_GIE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    gie_set_o |-> ($past(op_i) == 3'd5 && !$past(flush_o))); // R6
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o); // R9
  AST_FLUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> pc_o == $past(pc_o) + 1'b1); // R9
endmodule

// File: tb/test_pc_seq_unit.sv
`timescale 1ns/1ps
module test_pc_seq_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [10:0] lit_i;
  logic [7:0]  low_wdata_i;
  logic        lat_we_i;
  logic [4:0]  lat_wdata_i;
  logic [12:0] pc_o;
  logic [7:0]  pcl_o;
  logic [4:0]  lat_o;
  logic        gie_set_o, flush_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pc_seq_unit i_pc_seq_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lit_i(lit_i),
    .low_wdata_i(low_wdata_i), .lat_we_i(lat_we_i), .lat_wdata_i(lat_wdata_i),
    .pc_o(pc_o), .pcl_o(pcl_o), .lat_o(lat_o),
    .gie_set_o(gie_set_o), .flush_o(flush_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one operation for one edge; returns at the following falling edge
  task automatic issue(input logic [2:0] op, input logic [10:0] lit = '0,
                       input logic [7:0] d = '0, input logic lwe = 1'b0,
                       input logic [4:0] ld = '0);
    op_i = op; lit_i = lit; low_wdata_i = d; lat_we_i = lwe; lat_wdata_i = ld;
    @(negedge clk);
    op_i = 3'd0; lit_i = '0; low_wdata_i = '0; lat_we_i = 1'b0; lat_wdata_i = '0;
  endtask

  task automatic t_reset();
    check("R1 pc", pc_o, 13'h0000);
    check("R1 latch", lat_o, 5'h00);
    check("R1 flush", flush_o, 1'b0);
    check("R1 gie", gie_set_o, 1'b0);
  endtask

  task automatic t_step();
    issue(3'd0); issue(3'd0); issue(3'd0);
    check("R2 step", pc_o, 13'h0003);
    issue(3'd7);
    check("R2 reserved", pc_o, 13'h0004);
    check("R2 no flush", flush_o, 1'b0);
  endtask

  task automatic t_latch_read();
    issue(3'd0, '0, '0, 1'b1, 5'h1A);
    check("R8 latch", lat_o, 5'h1A);
    check("R8 low byte", pcl_o, pc_o[7:0]);
    issue(3'd0);
    check("R8 latch hold", lat_o, 5'h1A);
  endtask

  task automatic t_jump();
    issue(3'd1, 11'h123);
    check("R3 target", pc_o, 13'h1923);
    check("R9 flush", flush_o, 1'b1);
    issue(3'd1, 11'h000, '0, 1'b1, 5'h00);   // ignored during flush
    check("R9 ignored op", pc_o, 13'h1924);
    check("R9 ignored latch", lat_o, 5'h1A);
    check("R9 flush drop", flush_o, 1'b0);
  endtask

  task automatic t_wrap();
    issue(3'd0, '0, '0, 1'b1, 5'h18);
    issue(3'd1, 11'h7FF);
    check("R3 top page", pc_o, 13'h1FFF);
    issue(3'd0);
    check("R2 wrap", pc_o, 13'h0000);
    check("R8 low byte wrap", pcl_o, 8'h00);
  endtask

  task automatic t_call_ret();
    logic [12:0] p;
    issue(3'd0, '0, '0, 1'b1, 5'h00);
    p = pc_o;
    issue(3'd2, 11'h200);
    check("R4 call target", pc_o, 13'h0200);
    check("R4 flush", flush_o, 1'b1);
    issue(3'd0); issue(3'd0);
    issue(3'd3);
    check("R5 return", pc_o, p);
    check("R5 flush", flush_o, 1'b1);
    check("R6 no gie on return", gie_set_o, 1'b0);
    issue(3'd0);
    check("R9 after return", pc_o, p + 13'd1);
  endtask

  task automatic t_nested();
    logic [12:0] p1, p2;
    p1 = pc_o;
    issue(3'd2, 11'h300); issue(3'd0);
    p2 = pc_o;
    issue(3'd2, 11'h400); issue(3'd0);
    check("R4 nested target", pc_o, 13'h0401);
    issue(3'd4);
    check("R5 return literal", pc_o, p2);
    check("R6 no gie on retl", gie_set_o, 1'b0);
    issue(3'd0);
    issue(3'd5);
    check("R6 return intr", pc_o, p1);
    check("R6 gie pulse", gie_set_o, 1'b1);
    issue(3'd0);
    check("R6 gie one cycle", gie_set_o, 1'b0);
  endtask

  task automatic t_lowwr();
    issue(3'd0, '0, '0, 1'b1, 5'h08);
    issue(3'd1, 11'h0F7); issue(3'd0);
    check("R3 page", pc_o, 13'h08F8);
    issue(3'd6, '0, 8'h07);
    check("R7 no carry", pc_o, 13'h0807);
    check("R7 flush", flush_o, 1'b1);
    issue(3'd0);
    issue(3'd0, '0, '0, 1'b1, 5'h15);
    issue(3'd6, '0, 8'h40);
    check("R7 full latch", pc_o, 13'h1540);
    check("R8 low byte", pcl_o, 8'h40);
    issue(3'd0);
  endtask

  task automatic t_overflow();
    logic [12:0] v [9];
    issue(3'd0, '0, '0, 1'b1, 5'h00);
    for (int i = 0; i < 9; i++) begin
      v[i] = pc_o;
      issue(3'd2, 11'(12'h100 + 12'(i) * 12'h010));
      issue(3'd0);
    end
    for (int k = 0; k < 9; k++) begin
      issue(3'd3);
      check("R10 pop order", pc_o, (k < 8) ? v[8-k] : v[8]);
      issue(3'd0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; op_i = '0; lit_i = '0; low_wdata_i = '0; lat_we_i = 1'b0; lat_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_step();
    t_latch_read();
    t_jump();
    t_wrap();
    t_call_ret();
    t_nested();
    t_lowwr();
    t_overflow();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end
endmodule